// File: doc/BRIEF.md
# Signed Integer Divide Unit with Condition Flags

This unit divides a signed dividend by a signed divisor for a small processor datapath. A one-cycle `start` pulse loads both operands, the two destination register numbers and the current sign and zero flags. The unit then works on the operand magnitudes with an unsigned shift-subtract loop that produces one quotient bit per cycle. At the end it negates the quotient and remainder according to the operand signs. A one-cycle `done` pulse presents the results, the two register write enables, the destination numbers and the new overflow, sign and zero flags.

The flags follow the quotient, not the remainder. A zero divisor is detected at once. It finishes in a single cycle, raises overflow, blocks both register writes and hands back the incoming sign and zero flags unchanged. Dividing the most negative value by minus one gives defined results and raises overflow. When both destinations name the same register, only the remainder is written. Any other flags the processor keeps are not inputs or outputs of this unit, so it leaves them alone.

Top module: `sdiv_unit`

## Requirements
- R1: The quotient truncates toward zero and the remainder carries the sign of the dividend. For example, 45 / -6 gives -7 rem 3 and -45 / 6 gives -7 rem -3.
- R2: On a nonzero-divisor operation, `s` equals the sign bit (bit W-1) of the quotient, whatever the remainder's sign.
- R3: On a nonzero-divisor operation, `z` is 1 exactly when the quotient is 0, even when the remainder is nonzero. For example, 16 / 45 gives q 0, r 16, z 1.
- R4: A zero dividend with a nonzero divisor is a normal operation: q 0, r 0, `z` 1, `ov` 0, and both writes enabled.
- R5: A zero divisor gives `done` on the cycle after the `start` edge, with `ov` 1, `q_we` and `r_we` 0, and `s`/`z` equal to the `s_in`/`z_in` captured at start.
- R6: Dividend 0x80000000 divided by 0xFFFFFFFF (-1) gives `ov` 1, `s` 1, quotient 0x80000000 and remainder 0, with the writes enabled.
- R7: When `q_dst` equals `r_dst`, `q_we` stays 0 and `r_we` is 1, so the remainder is the value stored.
- R8: Every nonzero-divisor operation other than the R6 case gives `ov` 0.
- R9: For a nonzero divisor, `done` is a one-cycle pulse W+1 rising edges after the edge that takes `start`. `done` is never high while the unit is iterating.
- R10: A `start` that comes while a division is running is ignored. The running division's result and latency do not change, and no extra `done` follows.
- R11: After reset, `done`, `q_we` and `r_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request, taken only when idle |
| dividend | input | W | Signed dividend |
| divisor | input | W | Signed divisor |
| q_dst | input | AW | Quotient destination register number |
| r_dst | input | AW | Remainder destination register number |
| s_in | input | 1 | Current sign flag |
| z_in | input | 1 | Current zero flag |
| done | output | 1 | Result valid pulse |
| quotient | output | W | Signed quotient |
| remainder | output | W | Signed remainder |
| q_we | output | 1 | Quotient write enable, valid with done |
| r_we | output | 1 | Remainder write enable, valid with done |
| q_dst_o | output | AW | Captured quotient destination |
| r_dst_o | output | AW | Captured remainder destination |
| ov | output | 1 | Overflow flag, valid with done |
| s | output | 1 | Sign flag, valid with done |
| z | output | 1 | Zero flag, valid with done |

## Verification
Directed operands cover all four sign combinations of 45 and 6. These separate the truncation and remainder-sign rules from any flag taken off the remainder. Small dividends over larger divisors and a zero dividend show that `z` follows the quotient. Zero divisors are tried with both flag states fed in, which shows the flags are handed back rather than recomputed. The 0x80000000 / -1 case, equal destinations and a start pulse sent mid-division each cover their own rule. Random signed operands, with a zero divisor mixed in now and then, are compared against the truncating division computed in the bench.

// File: rtl/sdiv_unit.sv
module sdiv_unit #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  dividend,
  input  logic [W-1:0]  divisor,
  input  logic [AW-1:0] q_dst,
  input  logic [AW-1:0] r_dst,
  input  logic          s_in,
  input  logic          z_in,
  output logic          done,
  output logic [W-1:0]  quotient,
  output logic [W-1:0]  remainder,
  output logic          q_we,
  output logic          r_we,
  output logic [AW-1:0] q_dst_o,
  output logic [AW-1:0] r_dst_o,
  output logic          ov,
  output logic          s,
  output logic          z
);
  localparam int CW = $clog2(W + 1);
  localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};
  localparam logic [CW-1:0] ITERS = CW'(W);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [W-1:0]  acc, quo, dvs;
  logic          neg_q, neg_r, ovf;
  logic [W:0]    trial;
  logic [W-1:0]  qf, rf;
  logic          go;

  assign go    = start && !busy;
  assign trial = {acc, quo[W-1]} - {1'b0, dvs};
  assign qf    = neg_q ? -quo : quo;
  assign rf    = neg_r ? -acc : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; acc <= '0; quo <= '0; dvs <= '0;
      neg_q <= 1'b0; neg_r <= 1'b0; ovf <= 1'b0;
      done <= 1'b0; q_we <= 1'b0; r_we <= 1'b0;
      quotient <= '0; remainder <= '0; q_dst_o <= '0; r_dst_o <= '0;
      ov <= 1'b0; s <= 1'b0; z <= 1'b0;
    end else begin
      done <= 1'b0;
      q_we <= 1'b0;
      r_we <= 1'b0;
      if (go) begin
        q_dst_o <= q_dst;
        r_dst_o <= r_dst;
        if (divisor == '0) begin
          done <= 1'b1;
          ov   <= 1'b1;
          s    <= s_in;
          z    <= z_in;
        end else begin
          busy  <= 1'b1;
          cnt   <= ITERS;
          acc   <= '0;
          quo   <= dividend[W-1] ? -dividend : dividend;
          dvs   <= divisor[W-1] ? -divisor : divisor;
          neg_q <= dividend[W-1] ^ divisor[W-1];
          neg_r <= dividend[W-1];
          ovf   <= (dividend == MIN_VAL) && (divisor == '1);
        end
      end else if (busy) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
          if (!trial[W]) begin
            acc <= trial[W-1:0];
            quo <= {quo[W-2:0], 1'b1};
          end else begin
            acc <= {acc[W-2:0], quo[W-1]};
            quo <= {quo[W-2:0], 1'b0};
          end
        end else begin
          busy      <= 1'b0;
          done      <= 1'b1;
          quotient  <= qf;
          remainder <= rf;
          ov        <= ovf;
          s         <= qf[W-1];
          z         <= (qf == '0);
          r_we      <= 1'b1;
          q_we      <= (q_dst_o != r_dst_o);
        end
      end
    end
  end
endmodule

module sdiv_unit_chk #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic [W-1:0]  divisor,
  input logic          done,
  input logic [W-1:0]  quotient,
  input logic          q_we,
  input logic          r_we,
  input logic [AW-1:0] q_dst_o,
  input logic [AW-1:0] r_dst_o,
  input logic          ov,
  input logic          s,
  input logic          z
);
  assert_zero_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=> (done && ov && !q_we && !r_we));

  assert_same_dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && r_we && q_dst_o == r_dst_o) |-> !q_we);

  assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && r_we) |-> (z == (quotient == '0)));

  assert_sign_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && r_we) |-> (s == quotient[W-1]));

  assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  assert_we_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (q_we || r_we) |-> done);
endmodule

bind sdiv_unit sdiv_unit_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .divisor(divisor),
  .done(done), .quotient(quotient), .q_we(q_we), .r_we(r_we),
  .q_dst_o(q_dst_o), .r_dst_o(r_dst_o), .ov(ov), .s(s), .z(z)
);

// File: tb/sim_sdiv_unit.sv
module sim_sdiv_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int AW = 5;
  localparam logic [W-1:0] MIN_VAL = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, s_in = 1'b0, z_in = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic [AW-1:0] q_dst = '0, r_dst = '0;
  logic done, q_we, r_we, ov, s, z;
  logic [W-1:0] quotient, remainder;
  logic [AW-1:0] q_dst_o, r_dst_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdiv_unit #(.W(W), .AW(AW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input string lbl, input logic [W-1:0] dvd, input logic [W-1:0] dvs,
                       input logic [AW-1:0] qd, input logic [AW-1:0] rd,
                       input logic si, input logic zi, input bit poke_mid);
    logic [W-1:0] eq, er;
    bit dz, minc;
    int lat, n;
    dz   = (dvs == 0);
    minc = (dvd == MIN_VAL) && (dvs == '1);
    eq = '0; er = '0;
    if (!dz) begin
      if (minc) begin eq = MIN_VAL; er = '0; end
      else begin
        eq = $signed(dvd) / $signed(dvs);
        er = $signed(dvd) % $signed(dvs);
      end
    end
    lat = dz ? 1 : W + 2;
    @(negedge clk);
    dividend = dvd; divisor = dvs; q_dst = qd; r_dst = rd; s_in = si; z_in = zi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 60) begin
      if (poke_mid && n == 5) begin
        // R10: a second request with a zero divisor while busy must be ignored
        divisor = '0; dividend = 32'd99; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    chk(n == lat, {lbl, " R9/R5 latency"}, n, lat);
    chk(done == 1'b1, {lbl, " R9 done"}, done, 1);
    chk(ov == (dz || minc), {lbl, " R8/R5/R6 ov"}, ov, dz || minc);
    if (dz) begin
      chk(!q_we && !r_we, {lbl, " R5 writes blocked"}, {q_we, r_we}, 0);
      chk(s == si && z == zi, {lbl, " R5 flags kept"}, {s, z}, {si, zi});
    end else begin
      chk(quotient == eq, {lbl, " R1 quotient"}, quotient, eq);
      chk(remainder == er, {lbl, " R1 remainder"}, remainder, er);
      chk(s == eq[W-1], {lbl, " R2 sign"}, s, eq[W-1]);
      chk(z == (eq == 0), {lbl, " R3 zero"}, z, eq == 0);
      chk(r_we == 1'b1 && q_we == (qd != rd), {lbl, " R7 write enables"}, {q_we, r_we}, {qd != rd, 1'b1});
    end
    chk(q_dst_o == qd && r_dst_o == rd, {lbl, " dst"}, {q_dst_o, r_dst_o}, {qd, rd});
    @(negedge clk);
    chk(done == 1'b0, {lbl, " R9 pulse"}, done, 0);
    if (poke_mid) begin
      int extra = 0;
      repeat (W + 5) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk(extra == 0, {lbl, " R10 no extra done"}, extra, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 3);
    // R11: state held in reset
    chk(done == 0 && q_we == 0 && r_we == 0, "R11 reset outputs", {done, q_we, r_we}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && q_we == 0 && r_we == 0, "R11 after release", {done, q_we, r_we}, 0);

    do_op("R1 +/+", 32'd45, 32'd6, 5'd2, 5'd3, 0, 0, 0);
    do_op("R1 +/-", 32'd45, -32'sd6, 5'd2, 5'd3, 0, 0, 0);
    do_op("R1 -/+", -32'sd45, 32'd6, 5'd2, 5'd3, 0, 0, 0);
    do_op("R1 -/-", -32'sd45, -32'sd6, 5'd2, 5'd3, 1, 1, 0);
    do_op("R5 dz flags0", 32'd45, 32'd0, 5'd2, 5'd3, 0, 0, 0);
    do_op("R5 dz flags1", 32'd45, 32'd0, 5'd2, 5'd3, 1, 1, 0);
    do_op("R4 zero dividend", 32'd0, 32'd45, 5'd2, 5'd3, 1, 0, 0);
    do_op("R6 min by -1", MIN_VAL, 32'hFFFF_FFFF, 5'd2, 5'd3, 0, 1, 0);
    do_op("R3 small over big", 32'd16, 32'd45, 5'd2, 5'd3, 0, 0, 0);
    do_op("R7 same dst", 32'd45, 32'd6, 5'd4, 5'd4, 0, 0, 0);
    do_op("R10 start while busy", 32'd1000, 32'd7, 5'd1, 5'd9, 0, 0, 1);
    do_op("R8 min by 1", MIN_VAL, 32'd1, 5'd2, 5'd3, 0, 0, 0);

    for (int i = 0; i < 150; i++) begin
      logic [W-1:0] a, b;
      a = $urandom();
      b = ($urandom_range(0, 9) == 0) ? '0 : $urandom() >> $urandom_range(0, 30);
      if ($urandom_range(0, 1) == 1) b = -b;
      do_op("rand", a, b, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule